// File: doc/BRIEF.md
# Banked SRAM Address Decoder

This block sits between an 8-bit processor with a 16-bit address bus and a 2M×8 static RAM that needs 21 address lines. The processor can only see 64K at once, so the decoder splits its space into four 16K quarters. The bottom quarter and the top quarter are pinned to fixed physical pages: the bottom quarter always lands on physical page 0, and the top quarter always lands on the last physical page. Zero page, the stack and the reset and interrupt vectors therefore never move. The two middle quarters are paged through a 7-bit bank register that software writes. Both middle quarters show the same selected 16K page, so that page appears twice in the window from $4000 to $BFFF.

The fourteen low address lines always pass through unchanged. The seven upper SRAM lines come from a fixed pattern or from the bank register, depending on the quarter. The mapping is purely combinational from the processor address and the stored bank value, so it adds no wait state. The bank register loads on the falling edge of the phase-2 clock when its select strobe is high and the bus is in a write cycle. The active-low SRAM chip select is driven only while phase 2 is high and the bank register is not the target of the access.

Top module: `banked_sram_map`

## Requirements
- R1: For processor addresses $0000–$3FFF (address bits 15:14 = 2'b00), SRAM address bits 20:14 are all 0, whatever the bank register holds.
- R2: For processor addresses $C000–$FFFF (address bits 15:14 = 2'b11), SRAM address bits 20:14 are all 1, whatever the bank register holds.
- R3: For processor addresses $4000–$BFFF (address bits 15:14 = 2'b01 or 2'b10), SRAM address bits 20:14 equal the 7-bit bank register, so the two middle quarters reach the same physical page.
- R4: SRAM address bits 13:0 equal processor address bits 13:0 in every quarter.
- R5: The bank register loads data bits 6:0 on the falling edge of phase 2 only when the select strobe is 1 and R/W is 0 (write). Data bit 7 is discarded. A write cycle with the strobe at 0 leaves the register unchanged.
- R6: A read cycle (R/W = 1) with the select strobe at 1 leaves the bank register unchanged.
- R7: An active-high reset clears the bank register to 0 asynchronously.
- R8: The SRAM chip select (active low) is 0 only while phase 2 is 1 and the select strobe is 0. Otherwise it is 1.
- R9: The SRAM address follows a change of the processor address within the same phase, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | Phase-2 processor clock; the bank register loads on its falling edge |
| rst | input | 1 | Active-high asynchronous reset |
| cpu_addr | input | 16 | Processor address bus |
| cpu_data | input | 8 | Processor data bus (bits 6:0 feed the bank register) |
| cpu_rw | input | 1 | Processor R/W, 1 = read, 0 = write |
| bank_sel | input | 1 | Active-high strobe selecting the bank register |
| sram_addr | output | 21 | Physical SRAM address A0–A20 |
| sram_ce_n | output | 1 | Active-low SRAM chip select |

## Verification
The only state is the bank register, and the upper SRAM address lines show it directly whenever the address falls in a middle quarter. A wrong stored value therefore appears on the first paged access after the falling edge that loaded it, within half a phase-2 cycle. A fault that lets the register leak into a fixed quarter shows up on the first access to $0000–$3FFF or $C000–$FFFF after any non-zero bank is loaded. For that reason, the stimulus alternates between fixed and paged addresses under several non-zero bank values. A wrong chip-select decode is visible in the same phase, so the chip select is sampled in both the high and the low half of phase 2.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    typedef enum logic [1:0] {
        WIN_FIXED_LOW  = 2'd0,
        WIN_PAGED      = 2'd1,
        WIN_FIXED_HIGH = 2'd2
    } window_e;

endpackage

// File: rtl/bsd_window_decode.sv
module bsd_window_decode
    import bsd_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] quarter,
    output window_e          win
);
    localparam logic [SEL_W-1:0] LOW_CODE  = '0;
    localparam logic [SEL_W-1:0] HIGH_CODE = '1;

    always_comb begin
        if (quarter == LOW_CODE)
            win = WIN_FIXED_LOW;
        else if (quarter == HIGH_CODE)
            win = WIN_FIXED_HIGH;
        else
            win = WIN_PAGED;
    end
endmodule

// File: rtl/bsd_bank_reg.sv
module bsd_bank_reg #(
    parameter int BANK_W = 7
) (
    input  logic              phi2,
    input  logic              rst,
    input  logic              load,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank_q
);
    always_ff @(negedge phi2 or posedge rst) begin
        if (rst)
            bank_q <= '0;
        else if (load)
            bank_q <= din;
    end
endmodule

// File: rtl/bsd_addr_mux.sv
module bsd_addr_mux
    import bsd_pkg::*;
#(
    parameter int PASS_W = 14,
    parameter int BANK_W = 7
) (
    input  window_e           win,
    input  logic [PASS_W-1:0] low_bits,
    input  logic [BANK_W-1:0] bank_q,
    output logic [PASS_W+BANK_W-1:0] phys
);
    logic [BANK_W-1:0] upper;

    always_comb begin
        unique case (win)
            WIN_FIXED_LOW:  upper = '0;
            WIN_FIXED_HIGH: upper = '1;
            default:        upper = bank_q;
        endcase
    end

    assign phys = {upper, low_bits};
endmodule

// File: rtl/bsd_chip_select.sv
module bsd_chip_select (
    input  logic phi2,
    input  logic reg_access,
    output logic ce_n
);
    assign ce_n = ~(phi2 & ~reg_access);
endmodule

// File: rtl/banked_sram_map.sv
module banked_sram_map
    import bsd_pkg::*;
#(
    parameter int CPU_AW  = 16,
    parameter int DATA_W  = 8,
    parameter int SRAM_AW = 21,
    parameter int SEL_W   = 2
) (
    input  logic               phi2,
    input  logic               rst,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_data,
    input  logic               cpu_rw,
    input  logic               bank_sel,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               sram_ce_n
);
    localparam int PASS_W = CPU_AW - SEL_W;
    localparam int BANK_W = SRAM_AW - PASS_W;

    window_e           win;
    logic [BANK_W-1:0] bank_q;
    logic              bank_load;

    generate
        if (DATA_W > BANK_W) begin : g_spare
            logic unused_data_hi;
            assign unused_data_hi = ^cpu_data[DATA_W-1:BANK_W];
        end
    endgenerate

    assign bank_load = bank_sel & ~cpu_rw;

    bsd_window_decode #(.SEL_W(SEL_W)) u_win (
        .quarter (cpu_addr[CPU_AW-1:PASS_W]),
        .win     (win)
    );

    bsd_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .phi2   (phi2),
        .rst    (rst),
        .load   (bank_load),
        .din    (cpu_data[BANK_W-1:0]),
        .bank_q (bank_q)
    );

    bsd_addr_mux #(.PASS_W(PASS_W), .BANK_W(BANK_W)) u_mux (
        .win      (win),
        .low_bits (cpu_addr[PASS_W-1:0]),
        .bank_q   (bank_q),
        .phys     (sram_addr)
    );

    bsd_chip_select u_cs (
        .phi2       (phi2),
        .reg_access (bank_sel),
        .ce_n       (sram_ce_n)
    );
endmodule

// File: rtl/banked_sram_map_chk.sv
module banked_sram_map_chk (
    input logic        phi2,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        cpu_rw,
    input logic        bank_sel,
    input logic [20:0] sram_addr,
    input logic        sram_ce_n,
    input logic [6:0]  bank_q
);
    AST_LOW_QUARTER_ZERO: assert property (@(posedge phi2) disable iff (rst)
        (cpu_addr[15:14] == 2'b00) |-> (sram_addr[20:14] == 7'h00)); // R1
    AST_HIGH_QUARTER_ONES: assert property (@(posedge phi2) disable iff (rst)
        (cpu_addr[15:14] == 2'b11) |-> (sram_addr[20:14] == 7'h7f)); // R2
    AST_PAGED_USES_BANK: assert property (@(posedge phi2) disable iff (rst)
        (cpu_addr[15] != cpu_addr[14]) |-> (sram_addr[20:14] == bank_q)); // R3
    AST_LOW_BITS_PASS: assert property (@(posedge phi2) disable iff (rst)
        sram_addr[13:0] == cpu_addr[13:0]); // R4
    AST_BANK_LOADS: assert property (@(negedge phi2) disable iff (rst)
        (bank_sel && !cpu_rw) |=> (bank_q == $past(cpu_data[6:0]))); // R5
    AST_BANK_HOLDS: assert property (@(negedge phi2) disable iff (rst)
        !(bank_sel && !cpu_rw) |=> $stable(bank_q)); // R6
    AST_CE_OFF_LOW_PHASE: assert property (@(posedge phi2) disable iff (rst)
        sram_ce_n); // R8
    AST_CE_ON_HIGH_PHASE: assert property (@(negedge phi2) disable iff (rst)
        !bank_sel |-> !sram_ce_n); // R8
endmodule

bind banked_sram_map banked_sram_map_chk u_chk (
    .phi2      (phi2),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .cpu_rw    (cpu_rw),
    .bank_sel  (bank_sel),
    .sram_addr (sram_addr),
    .sram_ce_n (sram_ce_n),
    .bank_q    (bank_q)
);

// File: tb/banked_sram_map_tb.sv
module banked_sram_map_tb;
    logic        phi2 = 1'b0;
    logic        rst  = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw   = 1'b1;
    logic        bank_sel = 1'b0;
    logic [20:0] sram_addr;
    logic        sram_ce_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 phi2 = ~phi2;

    banked_sram_map u_dut (
        .phi2      (phi2),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .cpu_rw    (cpu_rw),
        .bank_sel  (bank_sel),
        .sram_addr (sram_addr),
        .sram_ce_n (sram_ce_n)
    );

    // {bank data written, processor address, expected SRAM address}
    localparam int NV = 10;
    localparam logic [44:0] VEC [NV] = '{
        {8'h05, 16'h1234, 21'h001234},  // R1
        {8'h05, 16'h5678, 21'h015678},  // R3
        {8'h05, 16'h9678, 21'h015678},  // R3 second quarter, same page
        {8'h05, 16'hC000, 21'h1FC000},  // R2
        {8'hFF, 16'h4001, 21'h1FC001},  // R5 bit 7 dropped
        {8'h80, 16'hBFFF, 21'h003FFF},  // R5 only bit 7 set
        {8'h2A, 16'h3FFF, 21'h003FFF},  // R1
        {8'h2A, 16'h7FFF, 21'h0ABFFF},  // R3 R4
        {8'h2A, 16'hFFFF, 21'h1FFFFF},  // R2
        {8'h41, 16'h8000, 21'h104000}   // R3
    };

    task automatic check(input bit ok, input string tag, input logic [20:0] act,
                         input logic [20:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_bank(input logic [7:0] d, input logic sel, input logic rw);
        @(posedge phi2); #1;
        bank_sel = sel; cpu_rw = rw; cpu_data = d;
        @(negedge phi2); #1;
        bank_sel = 1'b0; cpu_rw = 1'b1;
    endtask

    task automatic probe(input logic [15:0] a, input logic [20:0] exp, input string tag);
        cpu_addr = a;
        @(posedge phi2); #2;
        check(sram_addr === exp, tag, sram_addr, exp);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge phi2);
        #1 rst = 1'b0;
        @(negedge phi2); #2;
        check(sram_ce_n === 1'b1, "R8 low phase", {20'd0, sram_ce_n}, 21'd1);
        probe(16'h4000, 21'h000000, "R7 reset bank");
        check(sram_ce_n === 1'b0, "R8 high phase", {20'd0, sram_ce_n}, 21'd0);

        for (int i = 0; i < NV; i++) begin
            write_bank(VEC[i][44:37], 1'b1, 1'b0);
            probe(VEC[i][36:21], VEC[i][20:0], "R1/R2/R3/R4/R5 vector");
        end

        // bank now 7'h41
        write_bank(8'h33, 1'b1, 1'b1);
        probe(16'h4000, 21'h104000, "R6 read leaves bank");
        write_bank(8'h33, 1'b0, 1'b0);
        probe(16'h4000, 21'h104000, "R5 strobe low leaves bank");

        // select strobe during high phase blocks chip select
        @(posedge phi2); #1 bank_sel = 1'b1; cpu_rw = 1'b1; #1;
        check(sram_ce_n === 1'b1, "R8 strobe high", {20'd0, sram_ce_n}, 21'd1);
        @(negedge phi2); #1 bank_sel = 1'b0;

        // same-phase address follow
        @(posedge phi2); #1 cpu_addr = 16'h0010; #1;
        check(sram_addr === 21'h000010, "R9 same phase a", sram_addr, 21'h000010);
        cpu_addr = 16'h8010; #1;
        check(sram_addr === 21'h104010, "R9 same phase b", sram_addr, 21'h104010);

        // reset clears a loaded bank
        @(negedge phi2); #1 rst = 1'b1;
        repeat (2) @(negedge phi2);
        #1 rst = 1'b0;
        probe(16'h5555, 21'h001555, "R7 mid-run reset");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule